// File: doc/BRIEF.md
# Channel Service Scheduler

This block decides which of up to 32 channels is served next by a shared execution engine. Each channel has a fixed priority level (high, middle or low) or is switched off. A channel asks for service with a one-cycle pulse, and the request is held until the channel is served. Each time `decide` is high, the block takes the next entry of a repeating seven-slot level sequence. It picks one pending channel of that slot's level. If that level has nobody waiting, it tries the other levels. The result comes out as a registered channel number, its level and a valid flag.

Fairness inside a level comes from a per-channel "served" flag. A served channel cannot win again while another channel of its level still waits unserved. The served flags of a level are cleared all together, only when a channel of that level has just been served and no unserved request of that level remains. That clear opens a new round for the level.

Top module: `chan_sched`

## Requirements
- R1: A pulse on `req_in[c]` at a rising edge marks channel c pending. The pending mark counts for decisions at later edges and stays until the channel is served.
- R2: Among eligible channels of the chosen level (pending and not served this round), the lowest channel number wins.
- R3: Serving a channel clears its pending mark and sets its served flag. A served channel is not picked again while its level's flags are uncleared.
- R4: A level's served flags are cleared as a group, and only at an edge where a channel of that level is served while no other channel of that level is pending with a clear served flag.
- R5: Successive decisions use slot levels high, middle, high, low, high, middle, high, then repeat. After reset the sequence starts at its first entry. `slot_lvl` shows the slot level of the latest decision and reads 0 after reset.
- R6: When the slot level has no eligible channel, the levels are tried in this order: for a high slot middle then low, for a middle slot high then low, for a low slot high then middle.
- R7: A request arriving at the same edge as a grant or a group clear is not lost. It takes effect after the clear, including for the channel just served.
- R8: `grant_valid` is high for exactly the cycle after an edge with `decide` high at which some channel was eligible. Otherwise it is low.
- R9: Level codes in `lvl_cfg[2c+1:2c]` are 2 = high, 1 = middle, 0 = low and 3 = disabled. A disabled channel is never granted.
- R10: `grant_ch`, `grant_lvl` and `slot_lvl` are registered and change at the edge where `decide` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | NUM_CH | Per-channel service request pulses |
| lvl_cfg | input | 2*NUM_CH | Per-channel level code, static while running |
| decide | input | 1 | Make one scheduling decision at this edge |
| grant_valid | output | 1 | A channel was granted at the last decision |
| grant_ch | output | $clog2(NUM_CH) | Granted channel number |
| grant_lvl | output | 2 | Level of the granted channel |
| slot_lvl | output | 2 | Slot level used by the latest decision |

## Verification
A decision is made from the pending and served state that exists before the `decide` edge, and its results appear one edge later on the registered outputs. The bench therefore drives inputs on the falling edge, advances its own model at that moment, and compares the outputs 1 ns after the next rising edge. A request pulse counts only for decisions at later edges, so the model folds it in after computing the current grant. The bench checks the channel and level only when `grant_valid` is expected high, and it checks the slot level after every decision.

// File: rtl/chan_sched_pkg.sv
package chan_sched_pkg;
  localparam logic [1:0] LV_LOW  = 2'd0;
  localparam logic [1:0] LV_MID  = 2'd1;
  localparam logic [1:0] LV_HIGH = 2'd2;
  localparam logic [1:0] LV_OFF  = 2'd3;
  localparam int SEQ_LEN = 7;

  // level of slot i in the repeating sequence
  function automatic logic [1:0] slot_level(input logic [2:0] i);
    case (i)
      3'd1, 3'd5: return LV_MID;
      3'd3:       return LV_LOW;
      default:    return LV_HIGH;
    endcase
  endfunction

  // k-th level tried for a slot of level s (k = 0 is the slot itself)
  function automatic logic [1:0] try_level(input logic [1:0] s, input int k);
    logic [1:0] r;
    r = s;
    if (k == 1) r = (s == LV_HIGH) ? LV_MID : LV_HIGH;
    if (k == 2) r = (s == LV_LOW) ? LV_MID : LV_LOW;
    return r;
  endfunction
endpackage

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/sched_slot_seq.sv
module sched_slot_seq
  import chan_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [1:0] cur_lvl
);
  logic [2:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (adv) ptr_q <= (ptr_q == 3'(SEQ_LEN - 1)) ? 3'd0 : ptr_q + 3'd1;
  end

  assign cur_lvl = slot_level(ptr_q);
endmodule

// File: rtl/chan_sched.sv
module chan_sched
  import chan_sched_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         req_in,
  input  logic [2*NUM_CH-1:0]       lvl_cfg,
  input  logic                      decide,
  output logic                      grant_valid,
  output logic [$clog2(NUM_CH)-1:0] grant_ch,
  output logic [1:0]                grant_lvl,
  output logic [1:0]                slot_lvl
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int NLV  = 3;

  logic [NUM_CH-1:0]           srr_q, sgr_q;
  logic [NLV-1:0][NUM_CH-1:0]  lvl_mask, elig;
  logic [NLV-1:0]              lv_found;
  logic [NLV-1:0][CH_W-1:0]    lv_idx;
  logic [1:0]                  slot_cur;

  // named decision events
  logic                        fire;
  logic                        any_elig;
  logic [CH_W-1:0]             pick_ch;
  logic [1:0]                  pick_lvl;
  logic [NUM_CH-1:0]           gmask;
  logic [NLV-1:0]              grp_clr;

  sched_slot_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (decide),
    .cur_lvl (slot_cur)
  );

  for (genvar l = 0; l < NLV; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign lvl_mask[l][c] = (lvl_cfg[2*c +: 2] == 2'(l));
    end
    assign elig[l] = srr_q & ~sgr_q & lvl_mask[l];
    sched_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
      .vec   (elig[l]),
      .found (lv_found[l]),
      .idx   (lv_idx[l])
    );
    assign grp_clr[l] = fire && (pick_lvl == 2'(l)) && ((elig[l] & ~gmask) == '0);
  end

  assign any_elig = |lv_found;

  always_comb begin
    logic [1:0] lv;
    fire     = 1'b0;
    pick_ch  = '0;
    pick_lvl = LV_LOW;
    for (int k = 0; k < NLV; k++) begin
      lv = try_level(slot_cur, k);
      if (decide && !fire && lv_found[lv]) begin
        fire     = 1'b1;
        pick_lvl = lv;
        pick_ch  = lv_idx[lv];
      end
    end
  end

  assign gmask = fire ? (NUM_CH'(1) << pick_ch) : '0;

  logic [NUM_CH-1:0] sgr_next;
  always_comb begin
    sgr_next = sgr_q | gmask;
    for (int l = 0; l < NLV; l++)
      if (grp_clr[l]) sgr_next = sgr_next & ~lvl_mask[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr_q       <= '0;
      sgr_q       <= '0;
      grant_valid <= 1'b0;
      grant_ch    <= '0;
      grant_lvl   <= LV_LOW;
      slot_lvl    <= LV_LOW;
    end else begin
      srr_q       <= (srr_q & ~gmask) | req_in;
      sgr_q       <= sgr_next;
      grant_valid <= fire;
      if (fire) begin
        grant_ch  <= pick_ch;
        grant_lvl <= pick_lvl;
      end
      if (decide) slot_lvl <= slot_cur;
    end
  end
endmodule

// File: rtl/chan_sched_chk.sv
module chan_sched_chk #(
  parameter int NUM_CH = 32,
  parameter int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              decide,
  input logic              fire,
  input logic              any_elig,
  input logic [CH_W-1:0]   pick_ch,
  input logic [1:0]        pick_lvl,
  input logic [2:0]        grp_clr,
  input logic              grant_valid,
  input logic [CH_W-1:0]   grant_ch,
  input logic [NUM_CH-1:0] req_in,
  input logic [NUM_CH-1:0] srr_q,
  input logic [NUM_CH-1:0] sgr_q
);
  // R8
  valid_after_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $past(decide));
  // R8
  grant_when_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && any_elig) |=> (grant_valid && grant_ch == $past(pick_ch)));
  // R4
  clear_needs_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_clr != 3'b000) |-> (fire && grp_clr[pick_lvl]));
  // R4
  single_group_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_clr));
  // R3 R7
  served_request_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_in[pick_ch]) |=> !srr_q[$past(pick_ch)]);
  // R3
  served_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && grp_clr == 3'b000) |=> sgr_q[$past(pick_ch)]);
endmodule

bind chan_sched chan_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .decide      (decide),
  .fire        (fire),
  .any_elig    (any_elig),
  .pick_ch     (pick_ch),
  .pick_lvl    (pick_lvl),
  .grp_clr     (grp_clr),
  .grant_valid (grant_valid),
  .grant_ch    (grant_ch),
  .req_in      (req_in),
  .srr_q       (srr_q),
  .sgr_q       (sgr_q)
);

// File: tb/tb_chan_sched.sv
module tb_chan_sched;
  localparam int N  = 32;
  localparam int CW = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_in;
  logic [2*N-1:0]  lvl_cfg;
  logic            decide;
  logic            grant_valid;
  logic [CW-1:0]   grant_ch;
  logic [1:0]      grant_lvl;
  logic [1:0]      slot_lvl;

  always #2 clk = ~clk;

  chan_sched #(.NUM_CH(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .lvl_cfg(lvl_cfg),
    .decide(decide), .grant_valid(grant_valid), .grant_ch(grant_ch),
    .grant_lvl(grant_lvl), .slot_lvl(slot_lvl)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_srr, m_sgr;
  logic [1:0]   m_lvl [N];
  int           m_slot;
  logic         e_valid;
  int           e_ch;
  logic [1:0]   e_lvl, e_slot;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] seq_lvl(input int i);
    if (i == 1 || i == 5) return 2'd1;
    if (i == 3) return 2'd0;
    return 2'd2;
  endfunction

  function automatic logic [1:0] order_lvl(input logic [1:0] s, input int k);
    logic [1:0] t [3];
    if (s == 2'd2)      t = '{2'd2, 2'd1, 2'd0};
    else if (s == 2'd1) t = '{2'd1, 2'd2, 2'd0};
    else                t = '{2'd0, 2'd2, 2'd1};
    return t[k];
  endfunction

  task automatic model_step(input logic [N-1:0] req, input bit dec);
    bit pend;
    e_valid = 1'b0;
    if (dec) begin
      e_slot = seq_lvl(m_slot);
      for (int k = 0; k < 3; k++) begin
        logic [1:0] lv;
        lv = order_lvl(e_slot, k);
        for (int c = 0; c < N; c++)
          if (!e_valid && m_lvl[c] == lv && m_srr[c] && !m_sgr[c]) begin
            e_valid = 1'b1; e_ch = c; e_lvl = lv;
          end
      end
      if (e_valid) begin
        m_srr[e_ch] = 1'b0;
        m_sgr[e_ch] = 1'b1;
        pend = 0;
        for (int c = 0; c < N; c++)
          if (m_lvl[c] == e_lvl && m_srr[c] && !m_sgr[c]) pend = 1;
        if (!pend)
          for (int c = 0; c < N; c++)
            if (m_lvl[c] == e_lvl) m_sgr[c] = 1'b0;
      end
      m_slot = (m_slot + 1) % 7;
    end
    m_srr = m_srr | req;
  endtask

  task automatic cycle(input logic [N-1:0] req, input bit dec, input string tag);
    @(negedge clk);
    req_in = req;
    decide = dec;
    model_step(req, dec);
    @(posedge clk);
    #1;
    chk({tag, " R8 valid"}, grant_valid, e_valid);
    if (e_valid) begin
      chk({tag, " R2 channel"}, grant_ch, e_ch);
      chk({tag, " R6 level"}, grant_lvl, e_lvl);
    end
    if (dec) chk({tag, " R5 slot"}, slot_lvl, e_slot);
  endtask

  task automatic do_reset(input logic [2*N-1:0] cfg);
    rst_n = 1'b0;
    req_in = '0;
    decide = 1'b0;
    lvl_cfg = cfg;
    for (int c = 0; c < N; c++) m_lvl[c] = cfg[2*c +: 2];
    m_srr = '0; m_sgr = '0; m_slot = 0; e_slot = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset valid", grant_valid, 0);
    chk("R5 reset slot", slot_lvl, 0);
  endtask

  function automatic logic [N-1:0] bits(input int a, input int b, input int c);
    logic [N-1:0] v;
    v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [2*N-1:0] cfg;
    void'($urandom(32'd20240611));

    // directed: channels 0, 5, 9 high, all others disabled
    cfg = '1;
    cfg[0 +: 2] = 2'd2; cfg[10 +: 2] = 2'd2; cfg[18 +: 2] = 2'd2;
    do_reset(cfg);
    cycle(bits(0, 5, 9), 1'b0, "R1 latch");
    chk("R1 no decision no grant", grant_valid, 0);
    cycle(bits(0, -1, -1), 1'b1, "R2 first");
    chk("R2 lowest wins", grant_ch, 0);
    cycle('0, 1'b1, "R6 pass from mid");
    chk("R3 re-request waits", grant_ch, 5);
    cycle(bits(5, -1, -1), 1'b1, "R4 clear");
    chk("R3 last of round", grant_ch, 9);
    cycle('0, 1'b1, "R7 after clear");
    chk("R3 new round", grant_ch, 0);
    cycle('0, 1'b1, "R7 same edge");
    chk("R7 request kept", grant_ch, 5);
    cycle('0, 1'b1, "R8 empty");
    chk("R8 nothing eligible", grant_valid, 0);

    // disabled channel and passing to low
    cfg = '1;
    cfg[14 +: 2] = 2'd0;
    do_reset(cfg);
    cycle(bits(3, 7, -1), 1'b0, "R9 setup");
    cycle('0, 1'b1, "R9 high slot");
    chk("R6 high slot passes to low", grant_ch, 7);
    cycle('0, 1'b1, "R9 disabled");
    chk("R9 disabled never served", grant_valid, 0);

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int c = 0; c < N; c++) cfg[2*c +: 2] = 2'($urandom_range(0, 3));
      do_reset(cfg);
      for (int i = 0; i < 1500; i++) begin
        logic [N-1:0] r;
        r = $urandom & $urandom & ((ph % 2 == 0) ? $urandom : '1);
        cycle(r, ($urandom_range(0, 2) != 0), "R4/R7 random");
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule